// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is a single DMA channel. It moves data one beat at a time over a single-beat read port and a single-beat write port. A packed 32-bit configuration word sets its behaviour, together with a source start address, a destination start address, a block byte count and a repeat count. Each accepted hardware request runs one unit of work. The trigger mode picks that unit: one buffer, one whole block, or a block repeated several times. Each side has its own address pointer, which can stay fixed, count up or count down by a step of 1, 2, 4 or 8 bytes. A request is acknowledged in one of two ways. Either the channel pulses a handshake output, or it writes a programmed 32-bit word to a programmed address. The channel also passes a registered copy of its 2-bit priority level to an external arbiter.

A single state machine sequences the channel through five states:
- `ST_IDLE` waits for a request.
- `ST_READ` issues a read at the source pointer.
- `ST_WRITE` writes the returned word to the destination pointer and advances both pointers.
- `ST_ACKWR` issues the optional acknowledge write.
- `ST_FINISH` pulses the completion outputs.

The transitions are:
- **accept**: IDLE to READ, on a request.
- **next beat**: WRITE to READ.
- **repeat reload**: WRITE to READ, with both pointers and the block count reloaded.
- **unit end**: WRITE to ACKWR when acknowledge-by-write is set, or WRITE to FINISH otherwise.
- **ack issued**: ACKWR to FINISH.
- **retire**: FINISH to IDLE.

Configuration fields, the acknowledge settings and the error flag are sampled on every accept. Start addresses, the block count and the repeat count are sampled only when a new block begins.

Top module: `dma_chan_seq`

## Requirements
- R1: Each pointer follows its own 2-bit mode, with the source mode in configuration bits 1:0 and the destination mode in bits 3:2. Mode 10 adds the step after every beat, 11 subtracts it, and 00 or the reserved 01 leave the address unchanged.
- R2: The step is 1, 2, 4 or 8 bytes for size codes 00, 01, 10 and 11. The source size code is in bits 9:8 and the destination size code in bits 11:10.
- R3: Configuration bits 25:18 hold the buffer length minus one, so 0 means 1 beat and 127 means 128 beats. Any value above 127 acts as 128.
- R4: In buffer mode (bits 29:28 = 00), each request moves one buffer and later requests continue through the same block. When fewer bytes remain in the block than a full buffer, the final buffer is cut short, and `tc` pulses with that request's `done`.
- R5: In block mode (01), one request moves the entire block. A block count of 0 is treated as 1.
- R6: In repeated-block mode (10), one request moves the block rpt_cnt+1 times. Both pointers and the block count reload before each repetition, and `tc` pulses only once, after the last repetition.
- R7: Linked-list mode (11) moves data exactly like block mode and sets `err`. `err` holds until the next accepted request with another mode clears it.
- R8: `prio_out` equals the value `prio_cfg` held one clock earlier (00 low, 01 medium, 10 high, 11 very high).
- R9: With `ack_by_write` low, `req_ack` pulses together with `done`. With it high, the last data write is followed by one write of `ack_data` to `ack_addr` with `wr_word` set, and `req_ack` stays low.
- R10: `busy` is high from the cycle after accept until `done`. Requests that arrive while busy are ignored, and `done` is a one-cycle pulse at the end of each request.
- R11: After reset the channel is idle, with `busy`, `rd_en`, `wr_en`, `done`, `tc`, `req_ack` and `err` all low.
- R12: Each beat is a read in one cycle, then in the next cycle a write (with `wr_word` low) of the word the read returned. Read and write are never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_word | input | 32 | Packed channel configuration |
| prio_cfg | input | 2 | Channel priority level |
| src_base | input | AW | Source start address |
| dst_base | input | AW | Destination start address |
| blk_len | input | BLK_W | Block byte count |
| rpt_cnt | input | RPT_W | Extra block repetitions in repeated-block mode |
| ack_by_write | input | 1 | 1: acknowledge by register write |
| ack_addr | input | AW | Acknowledge write address |
| ack_data | input | DW | Acknowledge write value |
| req | input | 1 | Hardware transfer request |
| rd_en | output | 1 | Read strobe |
| rd_addr | output | AW | Read address |
| rd_data | input | DW | Read data, valid the cycle after rd_en |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | AW | Write address |
| wr_data | output | DW | Write data |
| wr_word | output | 1 | Write is the 32-bit acknowledge word |
| busy | output | 1 | Channel is working on a request |
| done | output | 1 | One-cycle end-of-request pulse |
| tc | output | 1 | Transfer-complete pulse |
| req_ack | output | 1 | Hardware acknowledge pulse |
| err | output | 1 | Linked-list mode was requested |
| prio_out | output | 2 | Registered priority level |

## Verification
The hardest case to reach is a buffer-mode block that the channel must carry across several requests. The pointers and remaining count have to survive between requests, and the last buffer must be cut short where the block ends. The bench builds this with a block length that is not a multiple of the buffer length. It then changes the trigger mode partway through a block, so the leftover bytes must finish under block mode from the saved pointers. Its reference model keeps its own pointer and count state across calls. A request pulsed in the middle of a transfer checks that nothing beyond the one queued unit appears.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        TRIG_BUF = 2'b00,
        TRIG_BLK = 2'b01,
        TRIG_RPT = 2'b10,
        TRIG_LL  = 2'b11
    } trig_e;

    typedef enum logic [1:0] {
        PM_FIXED = 2'b00,
        PM_RSVD  = 2'b01,
        PM_INC   = 2'b10,
        PM_DEC   = 2'b11
    } ptr_mode_e;

    localparam int BUF_W = 8;

    typedef struct packed {
        ptr_mode_e        src_mode;
        ptr_mode_e        dst_mode;
        logic [1:0]       src_size;
        logic [1:0]       dst_size;
        logic [BUF_W-1:0] buf_beats;
        trig_e            trig;
    } chan_cfg_t;

endpackage

// File: rtl/dma_cfg_decode.sv
module dma_cfg_decode
    import dma_seq_pkg::*;
(
    input  logic [31:0] cfg_word,
    output chan_cfg_t   cfg
);
    logic [7:0] len_fld;
    logic       unused_cfg_bits;

    assign len_fld = cfg_word[25:18];
    assign unused_cfg_bits = ^{cfg_word[31:30], cfg_word[27:26],
                               cfg_word[17:12], cfg_word[7:4]};

    always_comb begin
        cfg.src_mode  = ptr_mode_e'(cfg_word[1:0]);
        cfg.dst_mode  = ptr_mode_e'(cfg_word[3:2]);
        cfg.src_size  = cfg_word[9:8];
        cfg.dst_size  = cfg_word[11:10];
        cfg.trig      = trig_e'(cfg_word[29:28]);
        if (len_fld[7]) begin
            cfg.buf_beats = 8'd128;
        end else begin
            cfg.buf_beats = len_fld + 8'd1;
        end
    end
endmodule

// File: rtl/dma_ptr_unit.sv
module dma_ptr_unit
    import dma_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          step_en,
    input  ptr_mode_e     mode,
    input  logic [1:0]    size,
    output logic [AW-1:0] ptr
);
    logic [AW-1:0] step;

    assign step = AW'(1) << size;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= base;
        end else if (step_en) begin
            unique case (mode)
                PM_INC:  ptr <= ptr + step;
                PM_DEC:  ptr <= ptr - step;
                default: ptr <= ptr;
            endcase
        end
    end

    AST_FIXED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load && (mode == PM_FIXED || mode == PM_RSVD)) |=> (ptr == $past(ptr))); // R1
endmodule

// File: rtl/dma_count_unit.sv
module dma_count_unit #(
    parameter int BLK_W = 17,
    parameter int RPT_W = 8,
    parameter int BUF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_blk,
    input  logic [BLK_W-1:0] blk_len,
    input  logic [RPT_W-1:0] rpt_cnt,
    input  logic             reload_blk,
    input  logic             start_buf,
    input  logic [BUF_W-1:0] buf_beats,
    input  logic             beat,
    output logic             blk_last,
    output logic             buf_last,
    output logic             rpt_zero
);
    logic [BLK_W-1:0] blk_left;
    logic [BLK_W-1:0] blk_init_q;
    logic [BLK_W-1:0] blk_eff;
    logic [RPT_W-1:0] rpt_left;
    logic [BUF_W-1:0] buf_left;

    assign blk_eff = (blk_len == '0) ? BLK_W'(1) : blk_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_left   <= '0;
            blk_init_q <= '0;
            rpt_left   <= '0;
        end else if (start_blk) begin
            blk_left   <= blk_eff;
            blk_init_q <= blk_eff;
            rpt_left   <= rpt_cnt;
        end else if (reload_blk) begin
            blk_left   <= blk_init_q;
            rpt_left   <= rpt_left - RPT_W'(1);
        end else if (beat) begin
            blk_left   <= blk_left - BLK_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_left <= '0;
        end else if (start_buf) begin
            buf_left <= buf_beats;
        end else if (beat) begin
            buf_left <= buf_left - BUF_W'(1);
        end
    end

    assign blk_last = (blk_left == BLK_W'(1));
    assign buf_last = (buf_left == BUF_W'(1));
    assign rpt_zero = (rpt_left == '0);

    AST_BLK_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        beat |-> (blk_left != '0)); // R5
    AST_RPT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        reload_blk |-> (rpt_left != '0)); // R6
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int BLK_W = 17,
    parameter int RPT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      cfg_word,
    input  logic [1:0]       prio_cfg,
    input  logic [AW-1:0]    src_base,
    input  logic [AW-1:0]    dst_base,
    input  logic [BLK_W-1:0] blk_len,
    input  logic [RPT_W-1:0] rpt_cnt,
    input  logic             ack_by_write,
    input  logic [AW-1:0]    ack_addr,
    input  logic [DW-1:0]    ack_data,
    input  logic             req,
    output logic             rd_en,
    output logic [AW-1:0]    rd_addr,
    input  logic [DW-1:0]    rd_data,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [DW-1:0]    wr_data,
    output logic             wr_word,
    output logic             busy,
    output logic             done,
    output logic             tc,
    output logic             req_ack,
    output logic             err,
    output logic [1:0]       prio_out
);
    localparam int NSIDE = 2;

    typedef enum logic [2:0] {
        ST_IDLE, ST_READ, ST_WRITE, ST_ACKWR, ST_FINISH
    } state_e;

    state_e    state, state_nx;
    chan_cfg_t dec;

    ptr_mode_e  smode_q, dmode_q;
    logic [1:0] ssize_q, dsize_q;
    trig_e      trig_q;
    logic          ack_q;
    logic [AW-1:0] ack_addr_q;
    logic [DW-1:0] ack_data_q;
    logic fresh_q, tc_pend_q, err_q;
    logic [1:0] prio_q;

    logic accept, new_blk, beat, rpt_reload, blk_end, buf_end, unit_end;
    logic blk_last, buf_last, rpt_zero;

    logic [AW-1:0] base_in [NSIDE];
    logic [AW-1:0] base_q  [NSIDE];
    logic [AW-1:0] ld_val  [NSIDE];
    logic [AW-1:0] ptr     [NSIDE];
    ptr_mode_e     mode_sel[NSIDE];
    logic [1:0]    size_sel[NSIDE];

    dma_cfg_decode u_dec (.cfg_word(cfg_word), .cfg(dec));

    // control decode
    assign accept     = (state == ST_IDLE) && req;
    assign new_blk    = accept && fresh_q;
    assign beat       = (state == ST_WRITE);
    assign rpt_reload = beat && blk_last && (trig_q == TRIG_RPT) && !rpt_zero;
    assign blk_end    = beat && blk_last && !rpt_reload;
    assign buf_end    = beat && buf_last && (trig_q == TRIG_BUF);
    assign unit_end   = blk_end || buf_end;

    // per-side pointer generators
    assign base_in[0]  = src_base;
    assign base_in[1]  = dst_base;
    assign mode_sel[0] = smode_q;
    assign mode_sel[1] = dmode_q;
    assign size_sel[0] = ssize_q;
    assign size_sel[1] = dsize_q;

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        assign ld_val[g] = new_blk ? base_in[g] : base_q[g];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q[g] <= '0;
            end else if (new_blk) begin
                base_q[g] <= base_in[g];
            end
        end

        dma_ptr_unit #(.AW(AW)) u_ptr (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (new_blk || rpt_reload),
            .base    (ld_val[g]),
            .step_en (beat),
            .mode    (mode_sel[g]),
            .size    (size_sel[g]),
            .ptr     (ptr[g])
        );
    end

    dma_count_unit #(.BLK_W(BLK_W), .RPT_W(RPT_W), .BUF_W(BUF_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_blk  (new_blk),
        .blk_len    (blk_len),
        .rpt_cnt    (rpt_cnt),
        .reload_blk (rpt_reload),
        .start_buf  (accept),
        .buf_beats  (dec.buf_beats),
        .beat       (beat),
        .blk_last   (blk_last),
        .buf_last   (buf_last),
        .rpt_zero   (rpt_zero)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req) state_nx = ST_READ;
            ST_READ:   state_nx = ST_WRITE;
            ST_WRITE: begin
                if (unit_end) begin
                    state_nx = ack_q ? ST_ACKWR : ST_FINISH;
                end else begin
                    state_nx = ST_READ;
                end
            end
            ST_ACKWR:  state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // request-scoped registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smode_q    <= PM_FIXED;
            dmode_q    <= PM_FIXED;
            ssize_q    <= '0;
            dsize_q    <= '0;
            trig_q     <= TRIG_BUF;
            ack_q      <= 1'b0;
            ack_addr_q <= '0;
            ack_data_q <= '0;
            err_q      <= 1'b0;
        end else if (accept) begin
            smode_q    <= dec.src_mode;
            dmode_q    <= dec.dst_mode;
            ssize_q    <= dec.src_size;
            dsize_q    <= dec.dst_size;
            trig_q     <= dec.trig;
            ack_q      <= ack_by_write;
            ack_addr_q <= ack_addr;
            ack_data_q <= ack_data;
            err_q      <= (dec.trig == TRIG_LL);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fresh_q   <= 1'b1;
            tc_pend_q <= 1'b0;
            prio_q    <= 2'b00;
        end else begin
            prio_q <= prio_cfg;
            if (accept) begin
                fresh_q   <= 1'b0;
                tc_pend_q <= 1'b0;
            end else if (blk_end) begin
                fresh_q   <= 1'b1;
                tc_pend_q <= 1'b1;
            end
        end
    end

    // outputs by state
    always_comb begin
        rd_en   = 1'b0;
        wr_en   = 1'b0;
        wr_word = 1'b0;
        done    = 1'b0;
        rd_addr = ptr[0];
        wr_addr = ptr[1];
        wr_data = rd_data;
        unique case (state)
            ST_IDLE:   ;
            ST_READ:   rd_en = 1'b1;
            ST_WRITE:  wr_en = 1'b1;
            ST_ACKWR: begin
                wr_en   = 1'b1;
                wr_word = 1'b1;
                wr_addr = ack_addr_q;
                wr_data = ack_data_q;
            end
            ST_FINISH: done = 1'b1;
            default:   ;
        endcase
    end

    assign busy     = (state != ST_IDLE);
    assign tc       = done && tc_pend_q;
    assign req_ack  = done && !ack_q;
    assign err      = err_q;
    assign prio_out = prio_q;

    AST_SINGLE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en)); // R12
    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (wr_en && !wr_word)); // R12
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_MOVE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en || wr_en) |-> busy); // R10
    AST_HW_ACK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> (done && !ack_q)); // R9
    AST_TC_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> done); // R6
    AST_PRIO_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (prio_out == $past(prio_cfg))); // R8
    AST_ERR_STABLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(err)); // R7
endmodule

// File: tb/test_dma_chan_seq.sv
module test_dma_chan_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_word = '0;
    logic [1:0]  prio_cfg = '0;
    logic [31:0] src_base = '0, dst_base = '0;
    logic [16:0] blk_len = '0;
    logic [7:0]  rpt_cnt = '0;
    logic        ack_by_write = 1'b0;
    logic [31:0] ack_addr = '0, ack_data = '0;
    logic        req = 1'b0;
    logic        rd_en, wr_en, wr_word, busy, done, tc, req_ack, err;
    logic [31:0] rd_addr, wr_addr, wr_data;
    logic [31:0] rd_data = '0;
    logic [1:0]  prio_out;

    int checks = 0;
    int errors = 0;
    int n_done = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    dma_chan_seq i_dma_chan_seq (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .prio_cfg(prio_cfg),
        .src_base(src_base), .dst_base(dst_base), .blk_len(blk_len),
        .rpt_cnt(rpt_cnt), .ack_by_write(ack_by_write), .ack_addr(ack_addr),
        .ack_data(ack_data), .req(req), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_word(wr_word), .busy(busy), .done(done), .tc(tc), .req_ack(req_ack),
        .err(err), .prio_out(prio_out)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return a ^ 32'hC3C3_0000;
    endfunction

    // memory model: one-cycle read latency
    always @(posedge clk) if (rd_en) rd_data <= pat(rd_addr);

    // scoreboard queues
    int          q_kind[$];
    logic [31:0] q_addr[$];
    logic [31:0] q_data[$];
    logic [2:0]  q_flag[$];
    string       q_tag[$];

    task automatic push(input int k, input logic [31:0] a, input logic [31:0] d,
                        input logic [2:0] f, input string t);
        q_kind.push_back(k); q_addr.push_back(a); q_data.push_back(d);
        q_flag.push_back(f); q_tag.push_back(t);
    endtask

    task automatic chk(input bit ok, input string t, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && (wr_en || done)) begin
            int k; logic [31:0] a, d; logic [2:0] f; string t;
            if (q_kind.size() == 0) begin
                chk(1'b0, "R10 unexpected activity", {31'b0, wr_en, wr_addr}, 64'h0);
            end else begin
                k = q_kind.pop_front(); a = q_addr.pop_front(); d = q_data.pop_front();
                f = q_flag.pop_front(); t = q_tag.pop_front();
                if (wr_en) begin
                    chk(k == 0 && wr_addr == a && wr_data == d && wr_word == f[0], t,
                        {wr_addr, wr_data}, {a, d});
                end else begin
                    chk(k == 1 && {tc, req_ack, err} == f, t,
                        {61'b0, tc, req_ack, err}, {61'b0, f});
                    n_done++;
                end
            end
        end
    end

    // reference model state
    logic [31:0] m_src, m_dst, m_sb, m_db;
    int m_left, m_init, m_rpt;
    bit m_fresh = 1'b1;

    function automatic logic [31:0] adv(input logic [31:0] a, input int md, input int sz);
        if (md == 2) return a + (32'd1 << sz);
        if (md == 3) return a - (32'd1 << sz);
        return a;
    endfunction

    function automatic logic [31:0] mkcfg(input int sm, dm, ssz, dsz, lenf, trig);
        logic [31:0] c = '0;
        c[1:0] = 2'(sm); c[3:2] = 2'(dm); c[9:8] = 2'(ssz); c[11:10] = 2'(dsz);
        c[25:18] = 8'(lenf); c[29:28] = 2'(trig);
        return c;
    endfunction

    task automatic model_req(input logic [31:0] cw, input logic [31:0] sb, db,
                             input int blk, rpt, input bit ackm,
                             input logic [31:0] aa, ad, input string t);
        int sm = int'(cw[1:0]), dm = int'(cw[3:2]);
        int ssz = int'(cw[9:8]), dsz = int'(cw[11:10]);
        int trig = int'(cw[29:28]);
        int bb = cw[25] ? 128 : int'(cw[25:18]) + 1;
        int cnt = 0;
        bit stop = 0, fin = 0;
        if (m_fresh) begin
            m_sb = sb; m_db = db; m_src = sb; m_dst = db;
            m_init = (blk == 0) ? 1 : blk; m_left = m_init; m_rpt = rpt; m_fresh = 0;
        end
        while (!stop) begin
            push(0, m_dst, pat(m_src), 3'b000, t);
            m_src = adv(m_src, sm, ssz); m_dst = adv(m_dst, dm, dsz);
            m_left--; cnt++;
            if (m_left == 0) begin
                if (trig == 2 && m_rpt != 0) begin
                    m_rpt--; m_src = m_sb; m_dst = m_db; m_left = m_init;
                end else begin
                    fin = 1; m_fresh = 1; stop = 1;
                end
            end else if (trig == 0 && cnt == bb) begin
                stop = 1;
            end
        end
        if (ackm) push(0, aa, ad, 3'b001, t);
        push(1, 0, 0, {fin, !ackm, trig == 3}, t);
    endtask

    task automatic apply(input logic [31:0] cw, input logic [31:0] sb, db,
                         input int blk, rpt, input bit ackm,
                         input logic [31:0] aa, ad);
        cfg_word = cw; src_base = sb; dst_base = db; blk_len = 17'(blk);
        rpt_cnt = 8'(rpt); ack_by_write = ackm; ack_addr = aa; ack_data = ad;
    endtask

    task automatic wait_done(input int prev);
        while (n_done == prev) @(negedge clk);
        @(negedge clk);
    endtask

    // driver: one request, expected items pushed first
    task automatic do_req(input logic [31:0] cw, input logic [31:0] sb, db,
                          input int blk, rpt, input bit ackm,
                          input logic [31:0] aa, ad, input string t);
        int prev = n_done;
        @(negedge clk);
        apply(cw, sb, db, blk, rpt, ackm, aa, ad);
        model_req(cw, sb, db, blk, rpt, ackm, aa, ad, t);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk(busy == 1'b1, "R10 busy after accept", {63'b0, busy}, 64'h1);
        wait_done(prev);
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk({busy, rd_en, wr_en, done, tc, req_ack, err} == 7'b0, "R11 reset outputs",
            {57'b0, busy, rd_en, wr_en, done, tc, req_ack, err}, 64'h0);

        // R8 priority
        prio_cfg = 2'b10; @(negedge clk);
        chk(prio_out == 2'b10, "R8 prio high", {62'b0, prio_out}, 64'h2);
        prio_cfg = 2'b11; @(negedge clk);
        chk(prio_out == 2'b11, "R8 prio very high", {62'b0, prio_out}, 64'h3);

        // R5 R1 R2 R12 R9: block mode, both increment by 1
        do_req(mkcfg(2, 2, 0, 0, 0, 1), 32'h1000, 32'h2000, 5, 0, 0, 0, 0, "R5 block inc");
        // R1 R2: source decrement by 4, destination fixed
        do_req(mkcfg(3, 0, 2, 0, 0, 1), 32'h3100, 32'h4000, 4, 0, 0, 0, 0, "R1 dec4 fixed");
        // R1: reserved mode holds, destination step 8
        do_req(mkcfg(1, 2, 1, 3, 0, 1), 32'h5000, 32'h6000, 3, 0, 0, 0, 0, "R2 rsvd step8");
        // R4 R3: buffer of 4 over block of 10, last cut to 2
        do_req(mkcfg(2, 2, 1, 0, 3, 0), 32'h7000, 32'h8000, 10, 0, 0, 0, 0, "R4 buf first");
        do_req(mkcfg(2, 2, 1, 0, 3, 0), 32'h0, 32'h0, 10, 0, 0, 0, 0, "R4 buf second");
        do_req(mkcfg(2, 2, 1, 0, 3, 0), 32'h0, 32'h0, 10, 0, 0, 0, 0, "R4 buf cut short");
        // R3 clamp: field 200 acts as 128, then finish the block in block mode
        do_req(mkcfg(2, 3, 0, 0, 200, 0), 32'h9000, 32'hA800, 300, 0, 0, 0, 0, "R3 clamp 128");
        do_req(mkcfg(2, 3, 0, 0, 200, 1), 32'h0, 32'h0, 300, 0, 0, 0, 0, "R4 resume as block");
        // R6 repeated block
        do_req(mkcfg(2, 2, 0, 1, 0, 2), 32'hB000, 32'hC000, 3, 2, 0, 0, 0, "R6 repeat x3");
        // R9 acknowledge by write
        do_req(mkcfg(2, 2, 0, 0, 0, 1), 32'hD000, 32'hE000, 2, 0, 1,
               32'hF000_0010, 32'hDEAD_BEEF, "R9 ack write");
        // R7 linked-list acts as block with err, then cleared
        do_req(mkcfg(2, 2, 0, 0, 0, 3), 32'h1100, 32'h1200, 3, 0, 0, 0, 0, "R7 linked list");
        do_req(mkcfg(2, 2, 0, 0, 0, 1), 32'h1300, 32'h1400, 1, 0, 0, 0, 0, "R7 err cleared");
        // R5 zero count acts as one
        do_req(mkcfg(2, 2, 0, 0, 0, 1), 32'h1500, 32'h1600, 0, 0, 0, 0, 0, "R5 zero count");

        // R10 request while busy is ignored
        begin
            int prev = n_done;
            @(negedge clk);
            apply(mkcfg(2, 2, 0, 0, 0, 1), 32'h1700, 32'h1800, 6, 0, 0, 0, 0);
            model_req(cfg_word, src_base, dst_base, 6, 0, 0, 0, 0, "R10 ignore busy");
            req = 1'b1; @(negedge clk); req = 1'b0;
            repeat (3) @(negedge clk);
            req = 1'b1; repeat (2) @(negedge clk); req = 1'b0;
            wait_done(prev);
            repeat (10) @(negedge clk);
            chk(!busy && q_kind.size() == 0, "R10 no extra work",
                {31'b0, busy, 32'(q_kind.size())}, 64'h0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule